// File: doc/BRIEF.md
# Alpha-Blending Layer Compositor

This block builds one output pixel per clock for a raster the size of a programmable background. Two counters walk the raster in row-major order, wrapping at the configured width and height. Each pixel starts as a uniform background colour. A set of foreground layers is then laid over it, each one a rectangle placed by a horizontal and vertical pixel offset from the top-left corner of the background.

Every layer has an enable, a placement rectangle, a stacking level and an alpha source. The alpha source is fully opaque, a constant per-layer alpha, or an alpha value that arrives with each pixel of the layer's stream. Each cycle the block takes one pixel per layer, each with a validity flag, for the raster position currently being scanned.

The block blends the layers in a fixed-latency pipeline, one stage per stacking level, and emits the result with its coordinates. Background colour fields are min(CW,16) bits wide. When CW exceeds 16, each field is placed in the upper bits and the lower bits are filled with zeros. Stream buffering and frame-size negotiation sit outside the block.

Top module: `layer_mixer`

## Requirements
- R1: The scan position advances once per clock after reset: x counts from 0 to bg_width_i-1, then returns to 0 while y steps by one, and y returns to 0 after bg_height_i-1. Output pixels come out in scan order, one per cycle, each tagged with its own out_x_o/out_y_o.
- R2: While rst_ni is low, out_valid_o and out_pix_o are 0. The first valid output is the pixel at (0,0), and out_valid_o then stays high.
- R3: A pixel that no layer covers carries the uniform colour. Plane 0 comes from bg_c0_i, plane 1 from bg_c1_i and plane 2 from bg_c2_i. Plane p is found at out_pix_o[p*CW +: CW].
- R4: Layer i covers pixel (x,y) exactly when xoff ≤ x < xoff+w and yoff ≤ y < yoff+h. Its fields are at layer_xoff_i/layer_w_i[i*XW +: XW] and layer_yoff_i/layer_h_i[i*YW +: YW]. Any part of a layer that lies beyond the background is never shown.
- R5: A layer whose layer_en_i[i] is 0 does not change any output pixel.
- R6: At a pixel where px_valid_i[i] is 0, a covering layer is treated as transparent.
- R7: Alpha mode is layer_mode_i[2i+1:2i]. Mode 2'b00 (opaque) and mode 2'b11 (spare, also opaque) both replace the pixel below with the layer pixel, plane p of which is px_data_i[(3i+p)*CW +: CW].
- R8: Mode 2'b01 blends with the constant alpha a = layer_salpha_i[i*CW +: CW]. Each plane becomes (a*fg + (M-a)*below + floor(M/2)) / M, truncated, with M = 2^CW-1.
- R9: Mode 2'b10 uses the same formula with a = px_alpha_i[i*CW +: CW]. An alpha of 0 leaves the pixel below unchanged, and an alpha of M gives the layer pixel.
- R10: Stacking levels are applied from 0 upward, so a higher level ends up on top. Layer i's level is layer_level_i[i*LW +: LW]. If two layers share a level, only the lower-indexed one is shown. A layer whose level is N_LAYERS or more is not shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bg_width_i | input | XW | Background width in pixels |
| bg_height_i | input | YW | Background height in lines |
| bg_c0_i | input | BGW | Uniform colour, plane 0 |
| bg_c1_i | input | BGW | Uniform colour, plane 1 |
| bg_c2_i | input | BGW | Uniform colour, plane 2 |
| layer_en_i | input | N_LAYERS | Per-layer enable |
| layer_mode_i | input | 2*N_LAYERS | Per-layer alpha mode |
| layer_xoff_i | input | N_LAYERS*XW | Per-layer horizontal offset |
| layer_yoff_i | input | N_LAYERS*YW | Per-layer vertical offset |
| layer_w_i | input | N_LAYERS*XW | Per-layer width |
| layer_h_i | input | N_LAYERS*YW | Per-layer height |
| layer_level_i | input | N_LAYERS*LW | Per-layer stacking level |
| layer_salpha_i | input | N_LAYERS*CW | Per-layer constant alpha |
| px_valid_i | input | N_LAYERS | Layer pixel valid for the current position |
| px_data_i | input | N_LAYERS*3*CW | Layer pixels for the current position |
| px_alpha_i | input | N_LAYERS*CW | Layer stream alpha for the current position |
| out_valid_o | output | 1 | Output pixel valid |
| out_x_o | output | XW | Output pixel column |
| out_y_o | output | YW | Output pixel row |
| out_pix_o | output | 3*CW | Composited pixel |

## Verification
The bench goes after rectangle edges, including a layer that runs past the right and bottom of the background. An off-by-one in the coverage compare would shift or widen the layer by a column or row. It drives alpha values of 0 and full scale and a stream with gaps in its validity flag. A wrong rounding constant or divisor would move blended values by one code, and ignoring the flag would paint stale data. It reorders the stacking levels, repeats a level and gives an out-of-range level, where a wrong priority puts the wrong layer on top. It also shrinks the raster between frames, where a counter that wraps late or early would misalign every following coordinate.

// File: rtl/mix_pkg.sv
package mix_pkg;
  typedef enum logic [1:0] {
    AM_OPAQUE = 2'b00,
    AM_STATIC = 2'b01,
    AM_STREAM = 2'b10,
    AM_SPARE  = 2'b11
  } amode_e;
endpackage

// File: rtl/mix_raster.sv
module mix_raster #(
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  logic [XW:0] x_nx;
  logic [YW:0] y_nx;

  assign x_nx = {1'b0, x_o} + (XW+1)'(1);
  assign y_nx = {1'b0, y_o} + (YW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else if (x_nx >= {1'b0, width_i}) begin
      x_o <= '0;
      y_o <= (y_nx >= {1'b0, height_i}) ? '0 : y_nx[YW-1:0];
    end else begin
      x_o <= x_nx[XW-1:0];
    end
  end
endmodule

// File: rtl/mix_layer_sel.sv
module mix_layer_sel
  import mix_pkg::*;
#(
  parameter int N      = 3,
  parameter int CW     = 8,
  parameter int XW     = 12,
  parameter int YW     = 12,
  parameter int LW     = 2,
  parameter int BGW    = 8,
  parameter bit POS_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XW-1:0]     x_i,
  input  logic [YW-1:0]     y_i,
  input  logic [N-1:0]      en_i,
  input  logic [2*N-1:0]    mode_i,
  input  logic [N*XW-1:0]   xoff_i,
  input  logic [N*YW-1:0]   yoff_i,
  input  logic [N*XW-1:0]   w_i,
  input  logic [N*YW-1:0]   h_i,
  input  logic [N*LW-1:0]   lvl_i,
  input  logic [N*CW-1:0]   salpha_i,
  input  logic [BGW-1:0]    bg0_i,
  input  logic [BGW-1:0]    bg1_i,
  input  logic [BGW-1:0]    bg2_i,
  input  logic [N-1:0]      pvalid_i,
  input  logic [N*3*CW-1:0] pdata_i,
  input  logic [N*CW-1:0]   palpha_i,
  output logic              valid_o,
  output logic [XW-1:0]     x_o,
  output logic [YW-1:0]     y_o,
  output logic [3*CW-1:0]   bg_o,
  output logic [N-1:0]      apply_o,
  output logic [N*CW-1:0]   alpha_o,
  output logic [N*3*CW-1:0] fg_o
);
  localparam int PW = 3 * CW;

  logic [N-1:0]    hit;
  logic [N*CW-1:0] lalpha;
  logic [N-1:0]    s_apply;
  logic [N*CW-1:0] s_alpha;
  logic [N*PW-1:0] s_fg;
  logic [PW-1:0]   bg_d;

  for (genvar gi = 0; gi < N; gi++) begin : g_layer
    logic [XW-1:0] xo, lw;
    logic [YW-1:0] yo, lh;
    logic [XW:0]   xe;
    logic [YW:0]   ye;
    logic          in_x, in_y;
    logic [CW-1:0] la;

    assign xo   = xoff_i[gi*XW +: XW];
    assign lw   = w_i[gi*XW +: XW];
    assign yo   = yoff_i[gi*YW +: YW];
    assign lh   = h_i[gi*YW +: YW];
    assign xe   = {1'b0, xo} + {1'b0, lw};
    assign ye   = {1'b0, yo} + {1'b0, lh};
    assign in_x = (x_i >= xo) && ({1'b0, x_i} < xe);
    assign in_y = (y_i >= yo) && ({1'b0, y_i} < ye);
    assign hit[gi] = en_i[gi] && pvalid_i[gi] && in_x && in_y;

    always_comb begin
      unique case (amode_e'(mode_i[2*gi +: 2]))
        AM_STATIC: la = salpha_i[gi*CW +: CW];
        AM_STREAM: la = palpha_i[gi*CW +: CW];
        default:   la = '1;
      endcase
    end
    assign lalpha[gi*CW +: CW] = la;
  end

  if (POS_EN) begin : g_pos
    for (genvar gk = 0; gk < N; gk++) begin : g_slot
      logic          ap;
      logic [CW-1:0] al;
      logic [PW-1:0] fg;
      always_comb begin
        ap = 1'b0;
        al = '0;
        fg = '0;
        // descending scan: lowest index wins a shared level
        for (int i = N - 1; i >= 0; i--) begin
          if (lvl_i[i*LW +: LW] == LW'(gk)) begin
            ap = hit[i];
            al = lalpha[i*CW +: CW];
            fg = pdata_i[i*PW +: PW];
          end
        end
      end
      assign s_apply[gk]           = ap;
      assign s_alpha[gk*CW +: CW]  = al;
      assign s_fg[gk*PW +: PW]     = fg;
    end
  end else begin : g_idx
    assign s_apply = hit;
    assign s_alpha = lalpha;
    assign s_fg    = pdata_i;
  end

  if (CW <= 16) begin : g_bg_narrow
    assign bg_d = {bg2_i, bg1_i, bg0_i};
  end else begin : g_bg_wide
    assign bg_d = {bg2_i, {(CW-BGW){1'b0}}, bg1_i, {(CW-BGW){1'b0}},
                   bg0_i, {(CW-BGW){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      bg_o    <= '0;
      apply_o <= '0;
      alpha_o <= '0;
      fg_o    <= '0;
    end else begin
      valid_o <= 1'b1;
      x_o     <= x_i;
      y_o     <= y_i;
      bg_o    <= bg_d;
      apply_o <= s_apply;
      alpha_o <= s_alpha;
      fg_o    <= s_fg;
    end
  end
endmodule

// File: rtl/mix_blend_stage.sv
module mix_blend_stage #(
  parameter int N  = 3,
  parameter int CW = 8,
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int K  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XW-1:0]     x_i,
  input  logic [YW-1:0]     y_i,
  input  logic [3*CW-1:0]   acc_i,
  input  logic [N-1:0]      apply_i,
  input  logic [N*CW-1:0]   alpha_i,
  input  logic [N*3*CW-1:0] fg_i,
  output logic              valid_o,
  output logic [XW-1:0]     x_o,
  output logic [YW-1:0]     y_o,
  output logic [3*CW-1:0]   acc_o,
  output logic [N-1:0]      apply_o,
  output logic [N*CW-1:0]   alpha_o,
  output logic [N*3*CW-1:0] fg_o
);
  localparam int PW   = 3 * CW;
  localparam int MW   = 2 * CW + 2;
  localparam int AMAX = (1 << CW) - 1;

  logic [CW-1:0] a;
  logic [PW-1:0] fg, mixed;

  assign a  = alpha_i[K*CW +: CW];
  assign fg = fg_i[K*PW +: PW];

  always_comb begin
    for (int p = 0; p < 3; p++) begin
      logic [MW-1:0] num;
      num = MW'(a) * MW'(fg[p*CW +: CW])
          + (MW'(AMAX) - MW'(a)) * MW'(acc_i[p*CW +: CW])
          + MW'(AMAX / 2);
      mixed[p*CW +: CW] = CW'(num / MW'(AMAX));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      acc_o   <= '0;
      apply_o <= '0;
      alpha_o <= '0;
      fg_o    <= '0;
    end else begin
      valid_o <= valid_i;
      x_o     <= x_i;
      y_o     <= y_i;
      acc_o   <= apply_i[K] ? mixed : acc_i;
      apply_o <= apply_i;
      alpha_o <= alpha_i;
      fg_o    <= fg_i;
    end
  end
endmodule

// File: rtl/layer_mixer.sv
module layer_mixer #(
  parameter int N_LAYERS = 3,
  parameter int CW       = 8,
  parameter int XW       = 12,
  parameter int YW       = 12,
  parameter bit POS_EN   = 1'b1,
  localparam int LW      = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1,
  localparam int BGW     = (CW < 16) ? CW : 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [XW-1:0]              bg_width_i,
  input  logic [YW-1:0]              bg_height_i,
  input  logic [BGW-1:0]             bg_c0_i,
  input  logic [BGW-1:0]             bg_c1_i,
  input  logic [BGW-1:0]             bg_c2_i,
  input  logic [N_LAYERS-1:0]        layer_en_i,
  input  logic [2*N_LAYERS-1:0]      layer_mode_i,
  input  logic [N_LAYERS*XW-1:0]     layer_xoff_i,
  input  logic [N_LAYERS*YW-1:0]     layer_yoff_i,
  input  logic [N_LAYERS*XW-1:0]     layer_w_i,
  input  logic [N_LAYERS*YW-1:0]     layer_h_i,
  input  logic [N_LAYERS*LW-1:0]     layer_level_i,
  input  logic [N_LAYERS*CW-1:0]     layer_salpha_i,
  input  logic [N_LAYERS-1:0]        px_valid_i,
  input  logic [N_LAYERS*3*CW-1:0]   px_data_i,
  input  logic [N_LAYERS*CW-1:0]     px_alpha_i,
  output logic                       out_valid_o,
  output logic [XW-1:0]              out_x_o,
  output logic [YW-1:0]              out_y_o,
  output logic [3*CW-1:0]            out_pix_o
);
  localparam int N  = N_LAYERS;
  localparam int PW = 3 * CW;

  logic [XW-1:0] cnt_x;
  logic [YW-1:0] cnt_y;

  logic [N:0]       st_v;
  logic [XW-1:0]    st_x  [N+1];
  logic [YW-1:0]    st_y  [N+1];
  logic [PW-1:0]    st_acc[N+1];
  logic [N-1:0]     st_ap [N+1];
  logic [N*CW-1:0]  st_al [N+1];
  logic [N*PW-1:0]  st_fg [N+1];

  mix_raster #(.XW(XW), .YW(YW)) u_raster (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .width_i  (bg_width_i),
    .height_i (bg_height_i),
    .x_o      (cnt_x),
    .y_o      (cnt_y)
  );

  mix_layer_sel #(
    .N(N), .CW(CW), .XW(XW), .YW(YW), .LW(LW), .BGW(BGW), .POS_EN(POS_EN)
  ) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .x_i      (cnt_x),
    .y_i      (cnt_y),
    .en_i     (layer_en_i),
    .mode_i   (layer_mode_i),
    .xoff_i   (layer_xoff_i),
    .yoff_i   (layer_yoff_i),
    .w_i      (layer_w_i),
    .h_i      (layer_h_i),
    .lvl_i    (layer_level_i),
    .salpha_i (layer_salpha_i),
    .bg0_i    (bg_c0_i),
    .bg1_i    (bg_c1_i),
    .bg2_i    (bg_c2_i),
    .pvalid_i (px_valid_i),
    .pdata_i  (px_data_i),
    .palpha_i (px_alpha_i),
    .valid_o  (st_v[0]),
    .x_o      (st_x[0]),
    .y_o      (st_y[0]),
    .bg_o     (st_acc[0]),
    .apply_o  (st_ap[0]),
    .alpha_o  (st_al[0]),
    .fg_o     (st_fg[0])
  );

  for (genvar gk = 0; gk < N; gk++) begin : g_stage
    mix_blend_stage #(
      .N(N), .CW(CW), .XW(XW), .YW(YW), .K(gk)
    ) u_stg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (st_v[gk]),
      .x_i     (st_x[gk]),
      .y_i     (st_y[gk]),
      .acc_i   (st_acc[gk]),
      .apply_i (st_ap[gk]),
      .alpha_i (st_al[gk]),
      .fg_i    (st_fg[gk]),
      .valid_o (st_v[gk+1]),
      .x_o     (st_x[gk+1]),
      .y_o     (st_y[gk+1]),
      .acc_o   (st_acc[gk+1]),
      .apply_o (st_ap[gk+1]),
      .alpha_o (st_al[gk+1]),
      .fg_o    (st_fg[gk+1])
    );
  end

  assign out_valid_o = st_v[N];
  assign out_x_o     = st_x[N];
  assign out_y_o     = st_y[N];
  assign out_pix_o   = st_acc[N];
endmodule

// File: rtl/mix_checker.sv
module mix_checker #(
  parameter int N  = 3,
  parameter int XW = 12,
  parameter int YW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [XW-1:0] x_q,
  input logic [YW-1:0] y_q,
  input logic [N-1:0]  en_i,
  input logic [N-1:0]  sel_apply,
  input logic          out_valid,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y
);
  AST_X_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q != '0) |-> (x_q == $past(x_q) + XW'(1)));  // R1

  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q != '0) |-> $stable(y_q));  // R1

  AST_VALID_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid |=> out_valid);  // R2

  AST_FIRST_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid) |-> (out_x == '0 && out_y == '0));  // R2

  AST_EN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_apply) <= $countones($past(en_i)));  // R5
endmodule

bind layer_mixer mix_checker #(.N(N_LAYERS), .XW(XW), .YW(YW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .x_q       (cnt_x),
  .y_q       (cnt_y),
  .en_i      (layer_en_i),
  .sel_apply (st_ap[0]),
  .out_valid (out_valid_o),
  .out_x     (out_x_o),
  .out_y     (out_y_o)
);

// File: tb/sim_layer_mixer.sv
module sim_layer_mixer;
  localparam int CLK_P = 10;
  localparam int N  = 3;
  localparam int CW = 8;
  localparam int XW = 8;
  localparam int YW = 8;
  localparam int LW = 2;
  localparam int M  = 255;

  typedef struct {
    int          x;
    int          y;
    logic [23:0] pix;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [XW-1:0]     bg_w;
  logic [YW-1:0]     bg_h;
  logic [7:0]        bg0, bg1, bg2;
  logic [N-1:0]      en;
  logic [2*N-1:0]    mode;
  logic [N*XW-1:0]   xoff, lw;
  logic [N*YW-1:0]   yoff, lh;
  logic [N*LW-1:0]   lvl;
  logic [N*CW-1:0]   salpha;
  logic [N-1:0]      pvalid;
  logic [N*3*CW-1:0] pdata;
  logic [N*CW-1:0]   palpha;
  logic              o_valid;
  logic [XW-1:0]     o_x;
  logic [YW-1:0]     o_y;
  logic [3*CW-1:0]   o_pix;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int seed = 0;
  int aforce = -1;
  int vlayer = -1;
  int bw = 8;
  int bh = 4;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  layer_mixer #(.N_LAYERS(N), .CW(CW), .XW(XW), .YW(YW), .POS_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bg_width_i(bg_w), .bg_height_i(bg_h),
    .bg_c0_i(bg0), .bg_c1_i(bg1), .bg_c2_i(bg2), .layer_en_i(en),
    .layer_mode_i(mode), .layer_xoff_i(xoff), .layer_yoff_i(yoff),
    .layer_w_i(lw), .layer_h_i(lh), .layer_level_i(lvl),
    .layer_salpha_i(salpha), .px_valid_i(pvalid), .px_data_i(pdata),
    .px_alpha_i(palpha), .out_valid_o(o_valid), .out_x_o(o_x),
    .out_y_o(o_y), .out_pix_o(o_pix)
  );

  function automatic logic [7:0] pcol(int i, int p, int x, int y);
    return 8'((x*37 + y*59 + i*71 + p*13 + seed*29) & 255);
  endfunction

  function automatic logic [7:0] pal(int i, int x, int y);
    if (aforce >= 0) return 8'(aforce);
    return 8'((x*45 + y*17 + i*3 + seed*7) & 255);
  endfunction

  function automatic bit pval(int i, int x, int y);
    if (i == vlayer) return ((x + y) % 3) != 0;
    return 1'b1;
  endfunction

  // expected pixel built from R3..R10
  function automatic logic [23:0] model(int x, int y);
    int acc[3];
    acc[0] = bg0; acc[1] = bg1; acc[2] = bg2;
    for (int lv = 0; lv < N; lv++) begin
      int s = -1;
      for (int i = N - 1; i >= 0; i--)
        if (int'(lvl[i*LW +: LW]) == lv) s = i;
      if (s >= 0 && en[s] && pval(s, x, y) &&
          x >= int'(xoff[s*XW +: XW]) && x < int'(xoff[s*XW +: XW]) + int'(lw[s*XW +: XW]) &&
          y >= int'(yoff[s*YW +: YW]) && y < int'(yoff[s*YW +: YW]) + int'(lh[s*YW +: YW])) begin
        int a;
        case (mode[2*s +: 2])
          2'b01:   a = int'(salpha[s*CW +: CW]);
          2'b10:   a = int'(pal(s, x, y));
          default: a = M;
        endcase
        for (int p = 0; p < 3; p++)
          acc[p] = (a * int'(pcol(s, p, x, y)) + (M - a) * acc[p] + M/2) / M;
      end
    end
    return {8'(acc[2]), 8'(acc[1]), 8'(acc[0])};
  endfunction

  task automatic set_layer(int i, bit e, logic [1:0] md, int xo, int yo,
                           int w, int h, int lv, int sa);
    en[i] = e;
    mode[2*i +: 2] = md;
    xoff[i*XW +: XW] = XW'(xo);
    yoff[i*YW +: YW] = YW'(yo);
    lw[i*XW +: XW] = XW'(w);
    lh[i*YW +: YW] = YW'(h);
    lvl[i*LW +: LW] = LW'(lv);
    salpha[i*CW +: CW] = CW'(sa);
  endtask

  // driver: called at a negedge with the design at (0,0)
  task automatic drive_frames(int nf, string tag);
    for (int f = 0; f < nf; f++)
      for (int y = 0; y < bh; y++)
        for (int x = 0; x < bw; x++) begin
          exp_t e;
          for (int i = 0; i < N; i++) begin
            pvalid[i] = pval(i, x, y);
            palpha[i*CW +: CW] = pal(i, x, y);
            for (int p = 0; p < 3; p++)
              pdata[(3*i+p)*CW +: CW] = pcol(i, p, x, y);
          end
          e.x = x; e.y = y; e.pix = model(x, y); e.tag = tag;
          q.push_back(e);
          @(negedge clk);
        end
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && o_valid && !done && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(o_x) != e.x || int'(o_y) != e.y) begin
        errors++;
        $display("FAIL R1 coord: got (%0d,%0d) exp (%0d,%0d)", o_x, o_y, e.x, e.y);
      end
      checks++;
      if (o_pix !== e.pix) begin
        errors++;
        $display("FAIL %s pix at (%0d,%0d): got %h exp %h", e.tag, e.x, e.y, o_pix, e.pix);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bg_w = 8; bg_h = 4;
    bg0 = 8'h12; bg1 = 8'h34; bg2 = 8'h56;
    en = '0; mode = '0; xoff = '0; yoff = '0; lw = '0; lh = '0;
    lvl = '0; salpha = '0; pvalid = '0; pdata = '0; palpha = '0;
    for (int i = 0; i < N; i++) set_layer(i, 0, 2'b00, 0, 0, 8, 4, i, 0);
    repeat (3) @(negedge clk);
    checks++;
    if (o_valid !== 1'b0 || o_pix !== '0) begin
      errors++;
      $display("FAIL R2 reset: got valid=%b pix=%h exp 0/000000", o_valid, o_pix);
    end
    rst_n = 1'b1;

    // R3 R5 R1: nothing enabled, background only
    drive_frames(2, "R3/R5");

    // R4 R7 R5: opaque, spare code, clipped edge, disabled cover
    seed = 1;
    set_layer(0, 1, 2'b00, 2, 1, 3, 2, 0, 0);
    set_layer(1, 1, 2'b11, 6, 2, 5, 5, 1, 0);
    set_layer(2, 0, 2'b00, 0, 0, 8, 4, 2, 0);
    drive_frames(1, "R4/R7/R5");

    // R8 R6: static alpha under a gapped stream layer
    seed = 2; vlayer = 1;
    set_layer(0, 1, 2'b01, 0, 0, 8, 4, 0, 8'h60);
    set_layer(1, 1, 2'b10, 1, 1, 4, 3, 1, 0);
    set_layer(2, 0, 2'b00, 0, 0, 8, 4, 2, 0);
    drive_frames(1, "R8/R6");
    set_layer(0, 1, 2'b01, 0, 0, 8, 4, 0, 8'hFF);
    set_layer(1, 0, 2'b10, 1, 1, 4, 3, 1, 0);
    drive_frames(1, "R8");
    set_layer(0, 1, 2'b01, 0, 0, 8, 4, 0, 8'h00);
    drive_frames(1, "R8");
    vlayer = -1;

    // R9: stream alpha at 0, full scale, varying
    seed = 3;
    set_layer(0, 1, 2'b10, 0, 0, 8, 4, 0, 0);
    aforce = 0;   drive_frames(1, "R9");
    aforce = 255; drive_frames(1, "R9");
    aforce = -1;  drive_frames(1, "R9");

    // R10: ordering, shared level, out-of-range level
    seed = 4;
    set_layer(0, 1, 2'b01, 0, 0, 6, 3, 2, 8'h80);
    set_layer(1, 1, 2'b00, 2, 1, 4, 3, 0, 0);
    set_layer(2, 1, 2'b10, 4, 0, 4, 4, 1, 0);
    drive_frames(1, "R10");
    lvl = {2'd0, 2'd1, 2'd1};
    drive_frames(1, "R10");
    lvl = {2'd1, 2'd3, 2'd0};
    drive_frames(1, "R10");

    // R1: smaller raster
    seed = 5;
    lvl = {2'd2, 2'd1, 2'd0};
    bg_w = 5; bg_h = 3; bw = 5; bh = 3;
    drive_frames(2, "R1/R4");

    repeat (N + 4) @(negedge clk);
    done = 1'b1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 drain: got %0d pending exp 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule